// File: doc/BRIEF.md
# Ring-Buffer FIR Low-Pass with Bit Slicer

This block smooths the product stream of a tone discriminator and turns it into a recovered data bit. It holds 21 signed samples in a ring of registers. Each new sample overwrites the oldest slot in place, so no data ever moves. After a sample is accepted, one multiply-accumulate per clock runs over all 21 slots. A slot's coefficient is chosen by an index that starts at an offset derived from the write position. That index walks a table made of two copies of the coefficient set joined end to end, so the loop never needs an end-of-table test.

When the pass ends, the block raises a one-cycle done strobe. The 32-bit sum then stays on the accumulator output until the next sample is accepted. The data bit is taken from the upper half of that sum. While a pass is running, the upstream stage is held off through a ready signal.

Top module: `ring_fir_slicer`

## Requirements
- R1: After reset, in_ready is 1, done is 0, acc_out is 0, bit_out is 0. Every ring slot holds 0 and the write position is 0.
- R2: A sample is accepted on a rising edge where in_valid and in_ready are both 1. in_ready is 0 from that edge until the pass ends. A sample offered in that window waits and is not lost.
- R3: done is 1 for exactly one cycle, 21 rising edges after the accepting edge. in_ready is 1 in that cycle.
- R4: The accepted sample is written to ring slot wp. wp then advances by one and wraps from 20 to 0.
- R5: In a pass, ring slot q (0 to 20) is multiplied by entry q + (21 - wp) of the doubled table, where wp is the slot just written. Put another way, the sample of age a (0 = newest) is weighted by tap (21 - a) mod 21.
- R6: The taps 0..20 are 0, 84, 0, -284, -691, -796, 0, 1992, 4756, 7209, 8191, 7209, 4756, 1992, 0, -796, -691, -284, 0, 84, 0.
- R7: The accumulator is cleared on the accepting edge. acc_out is 0 in the next cycle. From done until the next accepted sample, acc_out holds the finished sum unchanged.
- R8: bit_out is 1 when acc_out[31:16], read as a signed number, is at least 1. Otherwise bit_out is 0.
- R9: Each product is the full signed 16x16 product. It is sign-extended and added into a signed 32-bit sum, with no rounding or truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is offered on in_sample |
| in_sample | input | 16 | Signed input sample |
| in_ready | output | 1 | Block can accept a sample |
| acc_out | output | 32 | Signed filter sum of the last pass |
| bit_out | output | 1 | Sliced data bit |
| done | output | 1 | One-cycle strobe: the pass has finished |

## Verification
Every output reads all 21 slots, so a wrong write position, a wrong coefficient offset or a corrupted slot shows up in acc_out. It appears at the very next done strobe, 21 cycles after the sample that exposes it, and goes on appearing until the bad slot is overwritten. A loop counter that stops early or late moves the done strobe off cycle 21 at once, and it also leaves out or repeats taps in the sum. A slicer fault shows only on sums whose upper half sits near the threshold, so the sample sequences force an upper half of exactly 1 as well as small positive and negative sums.

// File: rtl/ring_fir_pkg.sv
package ring_fir_pkg;

    localparam int RF_TAPS    = 21;
    localparam int RF_DATA_W  = 16;
    localparam int RF_COEF_W  = 16;
    localparam int RF_ACC_W   = 32;
    localparam int RF_IDX_W   = $clog2(RF_TAPS);
    localparam int RF_DIDX_W  = $clog2(2 * RF_TAPS);

    // Symmetric low-pass taps, grouped by mirror pairs.
    function automatic logic signed [RF_COEF_W-1:0] tap_coef(input int k);
        int v;
        case (k)
            10:      v = 8191;
            9, 11:   v = 7209;
            8, 12:   v = 4756;
            7, 13:   v = 1992;
            5, 15:   v = -796;
            4, 16:   v = -691;
            3, 17:   v = -284;
            1, 19:   v = 84;
            default: v = 0;
        endcase
        return RF_COEF_W'(v);
    endfunction

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic [RF_IDX_W-1:0]  q;
        logic [RF_IDX_W-1:0]  wp;
        logic [RF_DIDX_W-1:0] base;
    } ctl_t;

endpackage

// File: rtl/rfir_ring_buf.sv
module rfir_ring_buf #(
    parameter int DEPTH  = ring_fir_pkg::RF_TAPS,
    parameter int DATA_W = ring_fir_pkg::RF_DATA_W,
    parameter int IDX_W  = ring_fir_pkg::RF_IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [DATA_W-1:0] rd_data
);

    logic signed [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic signed [DATA_W-1:0] slot_d;

        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
        end
    end

endmodule

// File: rtl/rfir_coef_rom.sv
module rfir_coef_rom #(
    parameter int N_TAPS  = ring_fir_pkg::RF_TAPS,
    parameter int COEF_W  = ring_fir_pkg::RF_COEF_W,
    parameter int DIDX_W  = ring_fir_pkg::RF_DIDX_W,
    parameter bit DOUBLED = 1'b0
) (
    input  logic [DIDX_W-1:0]        didx,
    output logic signed [COEF_W-1:0] coef
);
    import ring_fir_pkg::*;

    if (DOUBLED) begin : g_doubled
        // Two copies back to back; index used as is.
        logic signed [COEF_W-1:0] tab [2*N_TAPS];
        for (genvar g = 0; g < 2 * N_TAPS; g++) begin : g_ent
            assign tab[g] = COEF_W'(tap_coef(g % N_TAPS));
        end
        always_comb begin
            coef = '0;
            for (int i = 0; i < 2 * N_TAPS; i++) begin
                if (didx == DIDX_W'(i)) coef = tab[i];
            end
        end
    end else begin : g_fold
        // Single copy; the doubled index is folded by one subtraction.
        logic [DIDX_W-1:0] k;
        always_comb begin
            k = (didx >= DIDX_W'(N_TAPS)) ? didx - DIDX_W'(N_TAPS) : didx;
        end
        assign coef = COEF_W'(tap_coef(int'(k)));
    end

endmodule

// File: rtl/rfir_mac.sv
module rfir_mac #(
    parameter int DATA_W = ring_fir_pkg::RF_DATA_W,
    parameter int COEF_W = ring_fir_pkg::RF_COEF_W,
    parameter int ACC_W  = ring_fir_pkg::RF_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] din,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [ACC_W-1:0]  acc
);

    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  acc_d, acc_q;

    always_comb begin
        prod     = din * coef;
        prod_ext = ACC_W'(prod);
        acc_d    = acc_q;
        if (clr)     acc_d = '0;
        else if (en) acc_d = acc_q + prod_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

endmodule

// File: rtl/rfir_slicer.sv
module rfir_slicer #(
    parameter int ACC_W  = ring_fir_pkg::RF_ACC_W,
    parameter int THRESH = 1
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic                    bit_o
);

    localparam int HALF = ACC_W / 2;
    localparam logic signed [HALF-1:0] TH = HALF'(THRESH);

    logic signed [HALF-1:0] upper;

    always_comb begin
        upper = acc[ACC_W-1 -: HALF];
        bit_o = (upper >= TH);
    end

endmodule

// File: rtl/ring_fir_slicer.sv
module ring_fir_slicer
    import ring_fir_pkg::*;
#(
    parameter bit USE_DOUBLED_ROM = 1'b0,
    parameter int SLICE_THRESH    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic signed [RF_DATA_W-1:0] in_sample,
    output logic                        in_ready,
    output logic signed [RF_ACC_W-1:0]  acc_out,
    output logic                        bit_out,
    output logic                        done
);

    localparam logic [RF_IDX_W-1:0]  LAST_IDX = RF_IDX_W'(RF_TAPS - 1);
    localparam logic [RF_DIDX_W-1:0] TAPS_D   = RF_DIDX_W'(RF_TAPS);

    ctl_t ctl_d, ctl_q;
    logic accept;

    logic signed [RF_DATA_W-1:0] rd_data;
    logic signed [RF_COEF_W-1:0] coef;
    logic [RF_DIDX_W-1:0]        didx;
    logic signed [RF_ACC_W-1:0]  acc;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        accept     = in_valid && !ctl_q.busy;

        if (accept) begin
            ctl_d.busy = 1'b1;
            ctl_d.q    = '0;
            ctl_d.base = TAPS_D - RF_DIDX_W'(ctl_q.wp);
            ctl_d.wp   = (ctl_q.wp == LAST_IDX) ? '0 : ctl_q.wp + 1'b1;
        end else if (ctl_q.busy) begin
            if (ctl_q.q == LAST_IDX) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.q = ctl_q.q + 1'b1;
            end
        end

        didx = RF_DIDX_W'(ctl_q.q) + ctl_q.base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rfir_ring_buf #(
        .DEPTH (RF_TAPS),
        .DATA_W(RF_DATA_W),
        .IDX_W (RF_IDX_W)
    ) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept),
        .wr_idx (ctl_q.wp),
        .wr_data(in_sample),
        .rd_idx (ctl_q.q),
        .rd_data(rd_data)
    );

    rfir_coef_rom #(
        .N_TAPS (RF_TAPS),
        .COEF_W (RF_COEF_W),
        .DIDX_W (RF_DIDX_W),
        .DOUBLED(USE_DOUBLED_ROM)
    ) u_rom (
        .didx(didx),
        .coef(coef)
    );

    rfir_mac #(
        .DATA_W(RF_DATA_W),
        .COEF_W(RF_COEF_W),
        .ACC_W (RF_ACC_W)
    ) u_mac (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .en   (ctl_q.busy),
        .din  (rd_data),
        .coef (coef),
        .acc  (acc)
    );

    rfir_slicer #(
        .ACC_W (RF_ACC_W),
        .THRESH(SLICE_THRESH)
    ) u_slice (
        .acc  (acc),
        .bit_o(bit_out)
    );

    assign in_ready = !ctl_q.busy;
    assign done     = ctl_q.done;
    assign acc_out  = acc;

endmodule

// File: rtl/ring_fir_slicer_chk.sv
module ring_fir_slicer_chk
    import ring_fir_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic signed [RF_ACC_W-1:0]  acc_out,
    input logic                        done
);

    logic [7:0] since_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        since_acc <= '0;
        else if (in_valid && in_ready)     since_acc <= 8'd1;
        else if (since_acc != '0 && since_acc <= 8'(RF_TAPS))
                                           since_acc <= since_acc + 8'd1;
    end

    p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_acc == 8'(RF_TAPS + 1)));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ready_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);

    p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (acc_out == '0));

    p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(acc_out));

endmodule

bind ring_fir_slicer ring_fir_slicer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .acc_out (acc_out),
    .done    (done)
);

// File: tb/ring_fir_slicer_test.sv
module ring_fir_slicer_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               in_ready;
    logic signed [31:0] acc_out;
    logic               bit_out;
    logic               done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int acc;
        bit b;
        int cyc;
    } exp_t;

    exp_t qexp[$];
    int   hist[21];
    int   taps[21] = '{0, 84, 0, -284, -691, -796, 0, 1992, 4756, 7209, 8191,
                       7209, 4756, 1992, 0, -796, -691, -284, 0, 84, 0};
    int   last_acc = 0;
    logic [15:0] lfsr = 16'hACE1;

    ring_fir_slicer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .in_ready (in_ready),
        .acc_out  (acc_out),
        .bit_out  (bit_out),
        .done     (done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: models a plain shift register, age a weighted by tap (21-a) mod 21.
    task automatic send(input int s);
        longint sum;
        exp_t   e;
        for (int a = 20; a > 0; a--) hist[a] = hist[a-1];
        hist[0] = s;
        sum = 0;
        for (int a = 0; a < 21; a++) sum += longint'(hist[a]) * taps[(21 - a) % 21];
        e.acc = int'(sum);
        e.b   = ((e.acc >>> 16) >= 1);
        @(negedge clk);
        if (in_ready) chk(acc_out == last_acc, "R7 hold", acc_out, last_acc);
        in_valid  = 1'b1;
        in_sample = 16'(s);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        e.cyc = cyc + 21;
        chk(in_ready == 1'b0, "R2 ready low", in_ready, 0);
        in_valid = 1'b0;
        last_acc = e.acc;
        qexp.push_back(e);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (qexp.size() == 0) begin
                chk(1'b0, "R3 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = qexp.pop_front();
                chk(acc_out == e.acc, "R4 R5 R6 R9 acc", acc_out, e.acc);
                chk(bit_out == e.b, "R8 bit", bit_out, e.b);
                chk(cyc == e.cyc, "R3 done cycle", cyc, e.cyc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 21; a++) hist[a] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(acc_out == 0, "R1 acc", acc_out, 0);
        chk(bit_out == 1'b0, "R1 bit", bit_out, 0);

        // Impulse: walks through every tap and the wp wrap (R4, R5)
        send(32767);
        for (int i = 0; i < 22; i++) send(0);
        // Constant positive
        for (int i = 0; i < 25; i++) send(10000);
        // Full-scale negative, largest magnitude sums (R9)
        for (int i = 0; i < 25; i++) send(-32768);
        // Alternating sign
        for (int i = 0; i < 25; i++) send((i % 2) ? 20000 : -20000);
        // Pseudo-random
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(int'($signed(lfsr)));
        end
        // Slicer boundary R8: upper half exactly 1 (sum 65536)
        for (int i = 0; i < 21; i++) send(0);
        send(10); send(0); send(814); send(0); send(0);
        // Small positive sum, upper half 0 (R8)
        for (int i = 0; i < 21; i++) send(0);
        send(1); send(0); send(0);
        // Small negative sum (R8)
        send(-1); send(0); send(0);

        repeat (30) @(negedge clk);
        chk(qexp.size() == 0, "R3 outputs missing", qexp.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule